// File: doc/BRIEF.md
# Configurable LUT Logic Slice

This block models one programmable logic slice. The slice holds two 16-entry lookup tables, and the mode register decides how those tables are used. In Logic mode they give two independent 4-input functions, or one 5-input function that picks between the tables with a fifth input. In ROM mode they act as two fixed 16x1 read-only memories. In RAM mode they become a 16x2 single-port memory that is written synchronously and read asynchronously.

Table contents and the mode are loaded through a parallel configuration port while `cfg_en_i` is high. While that port is active, all outputs are held low. Reset returns the slice to Logic mode and leaves the table contents untouched. Setting the parameter `RAM_EN` to 0 models a reduced slice with no write path, so RAM writes in that variant are ignored.

Top module: `lut_slice`

## Requirements
- R1: Reset (rst_ni low) sets the mode to Logic (encoding 2'b00). A slice configured in ROM mode behaves as Logic after a reset pulse.
- R2: Reset does not change table contents. After reset the outputs reflect the bits loaded before it.
- R3: In Logic mode, f0_o = T0[a0_i] and f1_o = T1[a1_i].
- R4: In Logic mode, f5_o = T1[a0_i] when a4_i is 1 and T0[a0_i] when a4_i is 0.
- R5: In ROM mode (2'b01), f0_o = T0[a0_i], f1_o = T1[a1_i] and f5_o = 0. In this mode we_i has no effect on the tables.
- R6: In RAM mode (2'b10) with RAM_EN=1, a rising clock edge with we_i high stores wdata_i[0] into T0[a0_i] and wdata_i[1] into T1[a0_i]. The new data is visible at f0_o/f1_o after that edge. Other entries are unchanged.
- R7: In RAM mode both tables are read at a0_i, and the read is combinational. Changing a0_i changes f0_o/f1_o in the same cycle. f5_o is 0.
- R8: While cfg_en_i is high, f0_o, f1_o and f5_o are 0. Each rising edge with cfg_en_i high loads T0 from cfg_data_i[15:0] and T1 from cfg_data_i[31:16] (bit index = table address), and loads the mode from mode_i.
- R9: With RAM_EN=0, writes in RAM mode are ignored: the table contents read back unchanged.
- R10: The mode encoding 2'b11 is loaded as Logic.
- R11: When cfg_en_i and we_i are high at the same edge, the configuration load wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (clears mode only) |
| cfg_en_i | input | 1 | Configuration load enable |
| mode_i | input | 2 | Mode loaded during configuration: 00 Logic, 01 ROM, 10 RAM, 11 Logic |
| cfg_data_i | input | 32 | Parallel table image: [15:0] table 0, [31:16] table 1 |
| a0_i | input | 4 | Table 0 address; shared address in RAM mode and for LUT5 |
| a1_i | input | 4 | Table 1 address in Logic and ROM modes |
| a4_i | input | 1 | Fifth input selecting the table for the LUT5 output |
| we_i | input | 1 | RAM write enable |
| wdata_i | input | 2 | RAM write data, bit g goes to table g |
| f0_o | output | 1 | Table 0 read result |
| f1_o | output | 1 | Table 1 read result |
| f5_o | output | 1 | LUT5 result in Logic mode, 0 otherwise |

## Verification
A corrupted table bit appears at f0_o or f1_o as soon as that address is presented, because reads pass through no register. A wrong mode register shows up in the same cycle as f5_o going nonzero in ROM or RAM mode, or as table 1 following the wrong address. A lost or misdirected RAM write is visible on the first cycle after the write edge, when the written address is read back. A write that leaks through in ROM mode or in the RAM-less variant is caught the same way.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;
  typedef enum logic [1:0] {
    MODE_LOGIC = 2'b00,
    MODE_ROM   = 2'b01,
    MODE_RAM   = 2'b10,
    MODE_RSVD  = 2'b11
  } slice_mode_e;
endpackage

// File: rtl/lut_slice_mode.sv
module lut_slice_mode
  import lut_slice_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_en_i,
  input  logic [1:0]  mode_i,
  output slice_mode_e mode_o
);
  slice_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_LOGIC;
    end else if (cfg_en_i) begin
      // reserved encoding folds onto Logic
      mode_q <= (mode_i == 2'b11) ? MODE_LOGIC : slice_mode_e'(mode_i);
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/lut_slice_table.sv
module lut_slice_table #(
  parameter int K = 4,
  localparam int DEPTH = 1 << K
) (
  input  logic             clk_i,
  input  logic             load_i,
  input  logic [DEPTH-1:0] load_data_i,
  input  logic             wr_i,
  input  logic [K-1:0]     wr_addr_i,
  input  logic             wr_bit_i,
  output logic [DEPTH-1:0] bits_o
);
  logic [DEPTH-1:0] bits_q;

  // no reset: contents survive rst_ni
  always_ff @(posedge clk_i) begin
    if (load_i) begin
      bits_q <= load_data_i;
    end else if (wr_i) begin
      bits_q[wr_addr_i] <= wr_bit_i;
    end
  end

  assign bits_o = bits_q;
endmodule

// File: rtl/lut_slice_outmux.sv
module lut_slice_outmux
  import lut_slice_pkg::*;
#(
  parameter int K = 4,
  localparam int DEPTH = 1 << K
) (
  input  slice_mode_e      mode_i,
  input  logic             cfg_en_i,
  input  logic [DEPTH-1:0] t0_i,
  input  logic [DEPTH-1:0] t1_i,
  input  logic [K-1:0]     a0_i,
  input  logic [K-1:0]     a1_i,
  input  logic             a4_i,
  output logic             f0_o,
  output logic             f1_o,
  output logic             f5_o
);
  always_comb begin
    f0_o = 1'b0;
    f1_o = 1'b0;
    f5_o = 1'b0;
    if (!cfg_en_i) begin
      case (mode_i)
        MODE_ROM: begin
          f0_o = t0_i[a0_i];
          f1_o = t1_i[a1_i];
        end
        MODE_RAM: begin
          f0_o = t0_i[a0_i];
          f1_o = t1_i[a0_i];
        end
        default: begin
          f0_o = t0_i[a0_i];
          f1_o = t1_i[a1_i];
          f5_o = a4_i ? t1_i[a0_i] : t0_i[a0_i];
        end
      endcase
    end
  end
endmodule

// File: rtl/lut_slice.sv
module lut_slice
  import lut_slice_pkg::*;
#(
  parameter int K = 4,
  parameter bit RAM_EN = 1'b1,
  localparam int DEPTH = 1 << K,
  localparam int NTAB = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_en_i,
  input  logic [1:0]            mode_i,
  input  logic [NTAB*DEPTH-1:0] cfg_data_i,
  input  logic [K-1:0]          a0_i,
  input  logic [K-1:0]          a1_i,
  input  logic                  a4_i,
  input  logic                  we_i,
  input  logic [NTAB-1:0]       wdata_i,
  output logic                  f0_o,
  output logic                  f1_o,
  output logic                  f5_o
);
  slice_mode_e      mode_q;
  logic             ram_we;
  logic [DEPTH-1:0] tbl_bits [NTAB];
  logic [DEPTH-1:0] t0_bits, t1_bits;

  lut_slice_mode i_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_en_i(cfg_en_i),
    .mode_i  (mode_i),
    .mode_o  (mode_q)
  );

  if (RAM_EN) begin : g_ram
    assign ram_we = we_i && !cfg_en_i && (mode_q == MODE_RAM);
  end else begin : g_no_ram
    assign ram_we = 1'b0;
  end

  for (genvar g = 0; g < NTAB; g++) begin : g_tab
    lut_slice_table #(.K(K)) i_table (
      .clk_i      (clk_i),
      .load_i     (cfg_en_i),
      .load_data_i(cfg_data_i[g*DEPTH +: DEPTH]),
      .wr_i       (ram_we),
      .wr_addr_i  (a0_i),
      .wr_bit_i   (wdata_i[g]),
      .bits_o     (tbl_bits[g])
    );
  end

  assign t0_bits = tbl_bits[0];
  assign t1_bits = tbl_bits[1];

  lut_slice_outmux #(.K(K)) i_outmux (
    .mode_i  (mode_q),
    .cfg_en_i(cfg_en_i),
    .t0_i    (t0_bits),
    .t1_i    (t1_bits),
    .a0_i    (a0_i),
    .a1_i    (a1_i),
    .a4_i    (a4_i),
    .f0_o    (f0_o),
    .f1_o    (f1_o),
    .f5_o    (f5_o)
  );
endmodule

// File: rtl/lut_slice_chk.sv
module lut_slice_chk #(
  parameter int K = 4,
  parameter bit RAM_EN = 1'b1,
  localparam int DEPTH = 1 << K
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_en_i,
  input logic [K-1:0]     a0_i,
  input logic             a4_i,
  input logic             we_i,
  input logic [1:0]       wdata_i,
  input logic             f0_o,
  input logic             f1_o,
  input logic             f5_o,
  input logic [1:0]       mode_q,
  input logic [DEPTH-1:0] t0_bits,
  input logic [DEPTH-1:0] t1_bits
);
  p_reset_logic_r1: assert property (@(posedge clk_i)
    !rst_ni |-> mode_q == 2'b00);

  p_lut5_select_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_en_i && mode_q == 2'b00) |-> f5_o == (a4_i ? t1_bits[a0_i] : t0_bits[a0_i]));

  p_rom_no_f5_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_en_i && mode_q == 2'b01) |-> !f5_o);

  p_rom_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_en_i && mode_q == 2'b01 && we_i) |=> ($stable(t0_bits) && $stable(t1_bits)));

  p_ram_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (RAM_EN && !cfg_en_i && mode_q == 2'b10 && we_i) |=>
      ((!cfg_en_i && $stable(a0_i)) |-> (f0_o == $past(wdata_i[0]) && f1_o == $past(wdata_i[1]))));

  p_cfg_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |-> (!f0_o && !f1_o && !f5_o));

  p_noram_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!RAM_EN && !cfg_en_i && we_i) |=> ($stable(t0_bits) && $stable(t1_bits)));

  p_rsvd_mode_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != 2'b11);
endmodule

bind lut_slice lut_slice_chk #(.K(K), .RAM_EN(RAM_EN)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cfg_en_i(cfg_en_i),
  .a0_i    (a0_i),
  .a4_i    (a4_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .f0_o    (f0_o),
  .f1_o    (f1_o),
  .f5_o    (f5_o),
  .mode_q  (mode_q),
  .t0_bits (t0_bits),
  .t1_bits (t1_bits)
);

// File: tb/test_lut_slice.sv
module test_lut_slice;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic [31:0] cfg_data = '0;
  logic [3:0]  a0 = '0, a1 = '0;
  logic        a4 = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  wdata = '0;
  logic        f0, f1, f5;
  logic        nf0, nf1, nf5;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] e0, e1;  // expected table images

  always #5 clk = ~clk;

  lut_slice i_lut_slice (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .mode_i(mode), .cfg_data_i(cfg_data),
    .a0_i(a0), .a1_i(a1), .a4_i(a4), .we_i(we), .wdata_i(wdata),
    .f0_o(f0), .f1_o(f1), .f5_o(f5)
  );

  lut_slice #(.RAM_EN(1'b0)) i_lut_slice_noram (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .mode_i(mode), .cfg_data_i(cfg_data),
    .a0_i(a0), .a1_i(a1), .a4_i(a4), .we_i(we), .wdata_i(wdata),
    .f0_o(nf0), .f1_o(nf1), .f5_o(nf5)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // drive after negedge, load on next posedge, release at following negedge
  task automatic configure(input logic [1:0] m, input logic [31:0] d);
    @(negedge clk);
    cfg_en = 1'b1; mode = m; cfg_data = d;
    #1 chk("R8 outputs low during cfg", {f0, f1, f5}, 3'b000);
    @(negedge clk);
    cfg_en = 1'b0;
    e0 = d[15:0]; e1 = d[31:16];
  endtask

  task automatic look(input logic [3:0] x0, input logic [3:0] x1, input logic x4);
    a0 = x0; a1 = x1; a4 = x4;
    #1;
  endtask

  task automatic test_reset_state();
    #1 chk("R8 reset state outputs low", {f0, f1, f5}, 3'b000);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic test_logic();
    configure(2'b00, 32'h9C3A_5E17);
    for (int i = 0; i < 16; i++) begin
      look(i[3:0], 4'(15 - i), 1'b0);
      chk("R3 logic f0/f1", {f0, f1, 1'b0}, {e0[i], e1[15-i], 1'b0});
      chk("R4 lut5 a4=0", {2'b00, f5}, {2'b00, e0[i]});
      look(i[3:0], 4'(15 - i), 1'b1);
      chk("R4 lut5 a4=1", {2'b00, f5}, {2'b00, e1[i]});
    end
  endtask

  task automatic test_rsvd();
    configure(2'b11, 32'hF0F0_0FF0);
    for (int i = 0; i < 16; i += 5) begin
      look(i[3:0], 4'(i + 1), 1'b1);
      chk("R10 reserved acts as logic", {f0, f1, f5}, {e0[i], e1[(i+1)%16], e1[i]});
    end
  endtask

  task automatic test_rom_and_reset();
    configure(2'b01, 32'h1234_ABCD);
    for (int i = 0; i < 16; i += 3) begin
      look(i[3:0], 4'(i ^ 5), 1'b1);
      chk("R5 rom read", {f0, f1, f5}, {e0[i], e1[i^5], 1'b0});
    end
    look(4'd2, 4'd2, 1'b0);
    we = 1'b1; wdata = {~e1[2], ~e0[2]};
    @(negedge clk);
    we = 1'b0;
    #1 chk("R5 rom ignores write", {f0, f1, 1'b0}, {e0[2], e1[2], 1'b0});
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    look(4'd6, 4'd9, 1'b1);
    chk("R1 logic after reset", {2'b00, f5}, {2'b00, e1[6]});
    chk("R2 tables kept", {f0, f1, 1'b0}, {e0[6], e1[9], 1'b0});
  endtask

  task automatic test_ram();
    configure(2'b10, 32'h0F0F_3C3C);
    look(4'd3, 4'd0, 1'b1);
    chk("R7 ram read shared addr", {f0, f1, f5}, {e0[3], e1[3], 1'b0});
    look(4'd4, 4'd0, 1'b1);
    chk("R7 async read", {f0, f1, f5}, {e0[4], e1[4], 1'b0});
    look(4'd3, 4'd0, 1'b0);
    we = 1'b1; wdata = {~e1[3], ~e0[3]};
    @(negedge clk);
    e0[3] = ~e0[3]; e1[3] = ~e1[3];
    a0 = 4'd12; wdata = {~e1[12], ~e0[12]};
    @(negedge clk);
    e0[12] = ~e0[12]; e1[12] = ~e1[12];
    we = 1'b0;
    for (int i = 0; i < 16; i++) begin
      look(i[3:0], 4'd0, 1'b0);
      chk("R6 ram contents after writes", {f0, f1, f5}, {e0[i], e1[i], 1'b0});
    end
  endtask

  task automatic test_cfg_beats_write();
    configure(2'b10, 32'hAAAA_5555);
    @(negedge clk);
    a0 = 4'd0; we = 1'b1; wdata = 2'b10; cfg_en = 1'b1; cfg_data = 32'h0000_FFFF; mode = 2'b10;
    @(negedge clk);
    cfg_en = 1'b0; we = 1'b0;
    e0 = 16'hFFFF; e1 = 16'h0000;
    look(4'd0, 4'd0, 1'b0);
    chk("R11 cfg wins over write", {f0, f1, f5}, 3'b100);
  endtask

  task automatic test_noram();
    configure(2'b10, 32'hC0DE_1234);
    look(4'd5, 4'd0, 1'b0);
    we = 1'b1; wdata = {~e1[5], ~e0[5]};
    @(negedge clk);
    we = 1'b0;
    #1 chk("R9 no-ram variant ignores write", {nf0, nf1, nf5}, {e0[5], e1[5], 1'b0});
    chk("R6 full variant writes", {f0, f1, f5}, {~e0[5], ~e1[5], 1'b0});
  endtask

  initial begin
    #(200000 * 10);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    test_reset_state();
    test_logic();
    test_rsvd();
    test_rom_and_reset();
    test_ram();
    test_cfg_beats_write();
    test_noram();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule